// File: doc/BRIEF.md
# Shared-Bus Arbiter with Processor Yield Slot

This block decides, cycle by cycle, which of seven requesters owns a shared system bus: four numbered DMA channels, one legacy DMA engine that always outranks them, a DSP and a CPU. A configuration word picks between strict priority and a rotating schedule. In the rotating schedule the DSP and CPU share one slot in the rotation. The slot runs for a power-of-two number of cycles and is skipped when neither processor is asking.

A DMA owner, whether legacy or channel, keeps the bus until the data path pulses `xfer_done` for its transfer. Processor grants are decided again on every cycle. All grants come from registers, so a decision made at one clock edge shows at the grant pins just after that edge. The rotation remembers the last channel it served. After a processor slot it starts again at channel 0.

Top module: `bus_arbiter`

## Requirements
- R1: At most one grant output is high in any cycle. After reset all grants are low.
- R2: Bit 31 of `cfg_ctrl` picks the scheme: 0 gives fixed priority and 1 gives round robin. A change takes effect at the next arbitration decision.
- R3: At every decision point `leg_req` wins in both schemes. In round robin it also cuts short a running processor slot.
- R4: In fixed mode channel 0 ranks highest and channel 3 lowest. The DSP and CPU get the bus only when no channel and no legacy request is pending.
- R5: A legacy or channel grant stays unchanged until a cycle in which `xfer_done` is high. The next owner is granted in the following cycle.
- R6: In round robin the candidates are visited in the order channel 0, 1, 2, 3, processor slot, starting just after the last channel served. The pointer starts at channel 0 after reset and after any processor slot. A candidate with no request is passed over.
- R7: `cfg_ctrl[19:16]` holds a code k that sets the processor slot length: 2^(k-1) cycles for k from 1 to 15. Code 0 removes the slot from the rotation.
- R8: A processor slot ends early in the first cycle in which neither the DSP nor the CPU requests. It is never entered while neither processor requests.
- R9: The DSP always wins over the CPU. Inside a slot, the winner is chosen again on every cycle.
- R10: In round robin, if no candidate in the rotation can be served but a processor requests, that processor is granted for one cycle and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_ctrl | input | 32 | Configuration: bit 31 selects the scheme, bits 19:16 hold the yield code |
| leg_req | input | 1 | Legacy DMA request |
| ch_req | input | 4 | DMA channel requests, bit i for channel i |
| dsp_req | input | 1 | DSP request |
| cpu_req | input | 1 | CPU request |
| xfer_done | input | 1 | The current DMA owner ends its transfer in this cycle |
| gnt_leg | output | 1 | Legacy DMA grant |
| gnt_ch | output | 4 | Channel grants |
| gnt_dsp | output | 1 | DSP grant |
| gnt_cpu | output | 1 | CPU grant |

## Verification
If the rotation pointer is wrong, the next contended decision grants the wrong channel one cycle after the preceding transfer ends. The bench catches this because it compares every cycle against an independent model. If the yield counter is wrong, a processor grant lasts longer or shorter than 2^(k-1) cycles; this shows only when the slot expires, so slot codes with short and very long slots are both run to their end. Fixed-mode decisions are swept over all 128 request patterns.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [2:0] {
    OWN_NONE = 3'd0,
    OWN_LEG  = 3'd1,
    OWN_CH   = 3'd2,
    OWN_DSP  = 3'd3,
    OWN_CPU  = 3'd4
  } owner_e;
endpackage

// File: rtl/bus_arb_rst_sync.sv
module bus_arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bus_arb_fixed_pick.sv
module bus_arb_fixed_pick #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           found,
  output logic [IW-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bus_arb_rot_pick.sv
module bus_arb_rot_pick #(
  parameter int NCAND = 5,
  localparam int PW = $clog2(NCAND)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCAND-1:0] cand,
  input  logic [PW-1:0]    ptr,
  output logic             found,
  output logic [PW-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int o = 0; o < NCAND; o++) begin
      int j;
      j = int'(ptr) + o;
      if (j >= NCAND) j = j - NCAND;
      if (!found && cand[j]) begin
        found = 1'b1;
        idx   = PW'(j);
      end
    end
  end

  // R6: a chosen candidate must actually be eligible
  assert_pick_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> cand[idx]);
  // R6: nothing eligible means nothing found
  assert_pick_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> !found);
endmodule

// File: rtl/bus_arb_slot_timer.sv
module bus_arb_slot_timer #(
  parameter int CODE_W = 4,
  localparam int CNT_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              start,
  input  logic              run,
  output logic              len_zero,
  output logic              last
);
  logic [CNT_W-1:0] cnt_q, cnt_d, len;
  logic             cnt_en;

  always_comb begin
    len      = (code == '0) ? '0 : (CNT_W'(1) << (code - CODE_W'(1)));
    len_zero = (code == '0);
    last     = (cnt_q >= len);
    cnt_en   = start | run;
    cnt_d    = start ? CNT_W'(1) : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: the slot is only extended while its length is not used up
  assert_slot_not_over_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !last);
  // R7: start and extend never coincide
  assert_slot_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && run));
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import bus_arb_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CFG_W     = 32,
  parameter int MODE_BIT  = 31,
  parameter int YIELD_LSB = 16,
  parameter int YIELD_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_ctrl,
  input  logic             leg_req,
  input  logic [NCH-1:0]   ch_req,
  input  logic             dsp_req,
  input  logic             cpu_req,
  input  logic             xfer_done,
  output logic             gnt_leg,
  output logic [NCH-1:0]   gnt_ch,
  output logic             gnt_dsp,
  output logic             gnt_cpu
);
  localparam int NCAND = NCH + 1;
  localparam int PW    = $clog2(NCAND);
  localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NGNT  = NCH + 3;

  logic arst_n;
  bus_arb_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(arst_n));

  owner_e         own_q, own_d;
  logic [IW-1:0]  chi_q, chi_d;
  logic [PW-1:0]  ptr_q, ptr_d;
  logic           slot_q, slot_d;

  logic              mode_rr;
  logic [YIELD_W-1:0] ycode;
  logic              proc_any, hold_dma, slot_go, slot_start;
  owner_e            proc_pick;
  logic              len_zero, slot_last;
  logic              fx_found, rr_found;
  logic [IW-1:0]     fx_idx;
  logic [PW-1:0]     rr_idx;
  logic [NCAND-1:0]  cand;

  assign mode_rr   = cfg_ctrl[MODE_BIT];
  assign ycode     = cfg_ctrl[YIELD_LSB +: YIELD_W];
  assign proc_any  = dsp_req | cpu_req;
  assign proc_pick = dsp_req ? OWN_DSP : OWN_CPU;
  assign cand      = {proc_any & ~len_zero, ch_req};

  bus_arb_fixed_pick #(.NCH(NCH)) u_fixed (.req(ch_req), .found(fx_found), .idx(fx_idx));

  bus_arb_rot_pick #(.NCAND(NCAND)) u_rot (
    .clk(clk), .rst_n(arst_n), .cand(cand), .ptr(ptr_q),
    .found(rr_found), .idx(rr_idx));

  bus_arb_slot_timer #(.CODE_W(YIELD_W)) u_timer (
    .clk(clk), .rst_n(arst_n), .code(ycode), .start(slot_start),
    .run(slot_go), .len_zero(len_zero), .last(slot_last));

  always_comb begin
    hold_dma   = ((own_q == OWN_LEG) || (own_q == OWN_CH)) && !xfer_done;
    slot_go    = !hold_dma && slot_q && mode_rr && proc_any && !leg_req && !slot_last;
    slot_start = 1'b0;
    own_d      = own_q;
    chi_d      = chi_q;
    ptr_d      = ptr_q;
    slot_d     = slot_q;
    if (hold_dma) begin
      own_d = own_q;
    end else if (slot_go) begin
      own_d = proc_pick;
    end else begin
      slot_d = 1'b0;
      if (leg_req) begin
        own_d = OWN_LEG;
      end else if (!mode_rr) begin
        if (fx_found) begin
          own_d = OWN_CH;
          chi_d = fx_idx;
        end else if (proc_any) begin
          own_d = proc_pick;
        end else begin
          own_d = OWN_NONE;
        end
      end else if (rr_found) begin
        if (rr_idx == PW'(NCH)) begin
          own_d      = proc_pick;
          slot_d     = 1'b1;
          slot_start = 1'b1;
          ptr_d      = '0;
        end else begin
          own_d = OWN_CH;
          chi_d = rr_idx[IW-1:0];
          ptr_d = rr_idx + PW'(1);
        end
      end else if (proc_any) begin
        own_d = proc_pick;
      end else begin
        own_d = OWN_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      own_q  <= OWN_NONE;
      chi_q  <= '0;
      ptr_q  <= '0;
      slot_q <= 1'b0;
    end else begin
      own_q  <= own_d;
      chi_q  <= chi_d;
      ptr_q  <= ptr_d;
      slot_q <= slot_d;
    end
  end

  always_comb begin
    gnt_leg = (own_q == OWN_LEG);
    gnt_dsp = (own_q == OWN_DSP);
    gnt_cpu = (own_q == OWN_CPU);
    gnt_ch  = '0;
    if (own_q == OWN_CH) gnt_ch[chi_q] = 1'b1;
  end

  logic [NGNT-1:0] gnt_all;
  logic            dma_owned;
  assign gnt_all   = {gnt_leg, gnt_dsp, gnt_cpu, gnt_ch};
  assign dma_owned = gnt_leg | (|gnt_ch);

  assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(gnt_all));
  assert_legacy_wins_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (leg_req && !(dma_owned && !xfer_done)) |=> gnt_leg);
  assert_fixed_no_proc_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (!mode_rr && (|ch_req) && !(dma_owned && !xfer_done)) |=> !(gnt_dsp || gnt_cpu));
  assert_dma_hold_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (dma_owned && !xfer_done) |=> $stable(gnt_all));
  assert_no_idle_slot_R8: assert property (@(posedge clk) disable iff (!arst_n)
    !proc_any |=> !(gnt_dsp || gnt_cpu));
  assert_dsp_first_R9: assert property (@(posedge clk) disable iff (!arst_n)
    dsp_req |=> !gnt_cpu);
endmodule

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_ctrl;
  logic        leg_req, dsp_req, cpu_req, xfer_done;
  logic [3:0]  ch_req;
  logic        gnt_leg, gnt_dsp, gnt_cpu;
  logic [3:0]  gnt_ch;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state: -1 none, 0..3 channel, 4 legacy, 5 dsp, 6 cpu
  int m_own, m_ptr, m_cnt;
  bit m_slot;

  always #10 clk = ~clk;

  bus_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .leg_req(leg_req),
    .ch_req(ch_req), .dsp_req(dsp_req), .cpu_req(cpu_req), .xfer_done(xfer_done),
    .gnt_leg(gnt_leg), .gnt_ch(gnt_ch), .gnt_dsp(gnt_dsp), .gnt_cpu(gnt_cpu));

  function automatic int dut_owner();
    int n, v;
    n = $countones({gnt_leg, gnt_dsp, gnt_cpu, gnt_ch});
    if (n > 1) return -2;
    v = -1;
    for (int i = 0; i < 4; i++) if (gnt_ch[i]) v = i;
    if (gnt_leg) v = 4;
    if (gnt_dsp) v = 5;
    if (gnt_cpu) v = 6;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: grant owner %0d, expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    int e_own, e_ptr, e_cnt, len, ppick;
    bit e_slot, rr, pany, found;
    string tag;
    e_own = m_own; e_ptr = m_ptr; e_cnt = m_cnt; e_slot = m_slot;
    rr    = cfg_ctrl[31];
    len   = (cfg_ctrl[19:16] == 0) ? 0 : (1 << (int'(cfg_ctrl[19:16]) - 1));
    pany  = dsp_req | cpu_req;
    ppick = dsp_req ? 5 : 6;
    if (m_own >= 0 && m_own <= 4 && !xfer_done) begin
      tag = "R5";
    end else if (m_slot && rr && pany && !leg_req && m_cnt < len) begin
      e_own = ppick; e_cnt = m_cnt + 1; tag = "R7/R9";
    end else begin
      e_slot = 0;
      if (leg_req) begin
        e_own = 4; tag = "R3";
      end else if (!rr) begin
        tag = "R4";
        e_own = pany ? ppick : -1;
        for (int c = 3; c >= 0; c--) if (ch_req[c]) e_own = c;
      end else begin
        found = 0; tag = "R6";
        for (int o = 0; o < 5; o++) begin
          int c;
          c = (m_ptr + o) % 5;
          if (!found && c < 4 && ch_req[c]) begin
            found = 1; e_own = c; e_ptr = c + 1;
          end else if (!found && c == 4 && pany && len > 0) begin
            found = 1; e_own = ppick; e_slot = 1; e_cnt = 1; e_ptr = 0; tag = "R7/R8";
          end
        end
        if (!found) begin
          e_own = pany ? ppick : -1; tag = "R10";
        end
      end
    end
    @(posedge clk);
    #1;
    check(tag, dut_owner(), e_own);
    m_own = e_own; m_ptr = e_ptr; m_cnt = e_cnt; m_slot = e_slot;
  endtask

  task automatic drive(input bit l, input logic [3:0] c, input bit d, input bit p, input bit dn);
    leg_req = l; ch_req = c; dsp_req = d; cpu_req = p; xfer_done = dn;
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung, expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_ctrl = 32'h0;
    drive(0, 4'h0, 0, 0, 0);
    m_own = -1; m_ptr = 0; m_cnt = 0; m_slot = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", dut_owner(), -1);

    // R4/R3/R9: fixed-mode sweep over all request patterns, each taken from a decision point
    for (int p = 0; p < 128; p++) begin
      drive(p[6], p[3:0], p[5], p[4], 1'b1);
      cyc();
    end

    // R2: switch to round robin, yield code 2 (two cycles)
    cfg_ctrl = 32'h8002_0000;
    for (int p = 0; p < 128; p++) begin
      drive(p[6], p[3:0], p[5], p[4], p[0] ^ p[2]);
      cyc();
      drive(p[6], p[3:0], p[5], p[4], 1'b1);
      cyc();
    end

    // R6: all channels and CPU requesting, code 3: 0,1,2,3,cpu x4,0...
    cfg_ctrl = 32'h8003_0000;
    for (int n = 0; n < 30; n++) begin
      drive(0, 4'hF, 0, 1, 1'b1);
      cyc();
    end

    // R8: slot cut short when processors stop
    cfg_ctrl = 32'h8004_0000;
    drive(0, 4'h0, 1, 0, 1'b1); cyc(); cyc();
    drive(0, 4'h4, 0, 0, 1'b1); cyc(); cyc();

    // R10: code 0 excludes the slot; processor only on an empty bus
    cfg_ctrl = 32'h8000_0000;
    for (int n = 0; n < 12; n++) begin
      drive(0, (n % 3 == 0) ? 4'h0 : 4'h3, 1, 1, 1'b1);
      cyc();
    end

    // random mixes across codes and modes, including R2 mode changes mid-stream
    for (int n = 0; n < 20000; n++) begin
      int r;
      r = int'($urandom);
      if (n % 500 == 0) cfg_ctrl = {r[31], 11'h0, 4'(r % 6), 16'h0};
      drive(r[8] & r[9] & r[10], 4'(r[7:4] & r[15:12]), r[1] & r[11], r[2],
            r[3] | r[16]);
      cyc();
    end

    // R7: longest slot, code 15 gives 16384 CPU cycles before channel 1 is served
    cfg_ctrl = 32'h800F_0000;
    drive(0, 4'h0, 0, 0, 1'b1); cyc();
    m_ptr = m_ptr;
    drive(0, 4'h2, 0, 1, 1'b1);
    for (int n = 0; n < 16390; n++) cyc();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule